// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block gives a small CPU one hardware breakpoint. A 16-bit match register is compared with the CPU address bus. The breakpoint has two flavours. In forced mode, any access to the matching address arms a request. The request is issued at the next instruction boundary. In tagged mode, only an opcode fetched from the matching address is marked. The halt is then requested in place of executing that opcode, when it reaches the head of the instruction queue. An opcode that is flushed from the queue never causes a halt.

Software programs the unit through a byte-wide write port. Select code 0 writes the control byte, 1 writes the high half of the match value and 2 writes the low half. The forced path is a two-state machine: `FS_IDLE` and `FS_PEND`.

- `FS_IDLE` → `FS_PEND` on an armed hit.
- `FS_PEND` → `FS_IDLE` when a boundary issues the request and no new hit arrives in that cycle.
- `FS_PEND` → `FS_PEND` when a boundary coincides with a new hit.
- `FS_PEND` → `FS_IDLE` when the unit is disabled or switched to tagged mode.

The tagged path keeps one tag bit per instruction queue slot. These bits are pushed on fetch, popped on head execute and cleared on flush.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset the unit is disabled and the match value is 0x0000; no halt request is raised, even for accesses to address 0x0000.
- R2: While the enable bit is 0, halt_req stays low in both modes for every input pattern.
- R3: Control byte (select code 0): bit 0 is enable, bit 1 selects the mode (1 = forced, 0 = tagged); other bits are ignored.
- R4: Select code 1 writes match bits 15:8 and select code 2 writes bits 7:0, each leaving the other half unchanged; select code 3 changes nothing.
- R5: In forced mode, an access (bus_access = 1) with bus_addr equal to the match value raises halt_req during the first insn_boundary cycle strictly after the access cycle; a boundary in the access cycle itself does not issue it.
- R6: Accesses to any other address raise no halt.
- R7: halt_req is a one-cycle pulse, and one pending hit yields exactly one request; a hit in the same cycle as the issuing boundary arms a new request for the following boundary.
- R8: In tagged mode, an opcode fetch (bus_fetch = 1) from the match address is tagged; halt_req is raised in the cycle q_head_exec presents that opcode, and not for untagged opcodes ahead of or behind it.
- R9: q_flush discards all tags; a flushed tagged opcode never causes a halt. A fetch in the flush cycle enters the emptied queue.
- R10: In tagged mode, a non-fetch access to the match address followed by boundaries raises no halt.
- R11: Clearing enable or selecting tagged mode while a forced request is pending drops it; re-enabling does not revive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 match high, 2 match low, 3 none |
| cfg_wdata | input | 8 | Write data byte |
| bus_addr | input | 16 | CPU address bus |
| bus_access | input | 1 | Any bus access this cycle |
| bus_fetch | input | 1 | Opcode fetch into the instruction queue this cycle |
| insn_boundary | input | 1 | Instruction boundary pulse |
| q_head_exec | input | 1 | Opcode at queue head is about to execute |
| q_flush | input | 1 | Instruction queue is flushed |
| halt_req | output | 1 | One-cycle request to enter the halted background state |

## Verification
A forced state machine that is stuck in `FS_PEND`, or that drops out of it, shows at the very next insn_boundary. It appears either as an extra or repeated halt pulse or as a missing one, so every vector pairs hits with boundaries one and two cycles later. A misaligned tag bit in the queue model shows only when the affected opcode reaches the head. The tagged tests therefore execute untagged neighbours on both sides of the tagged one, and also execute after a flush. A wrong byte lane in the match register shows up as a miss at the intended address, and the bench probes both halves separately.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_MATCHH = 2'd1,
        SEL_MATCHL = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic forced;   // control bit 1
        logic enable;   // control bit 0
    } bkpt_ctrl_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_PEND = 1'b1
    } force_state_e;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [HALF_W-1:0] cfg_wdata,
    output bkpt_ctrl_t        ctrl,
    output logic [ADDR_W-1:0] match_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            match_addr <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_CTRL: begin
                    ctrl.enable <= cfg_wdata[0];
                    ctrl.forced <= cfg_wdata[1];
                end
                SEL_MATCHH: match_addr[ADDR_W-1:HALF_W] <= cfg_wdata;
                SEL_MATCHL: match_addr[HALF_W-1:0]      <= cfg_wdata;
                SEL_NONE:   ;
            endcase
        end
    end

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (cfg_sel == SEL_MATCHH || cfg_sel == SEL_MATCHL)) |=> $stable(match_addr)); // R4

endmodule

// File: rtl/bkpt_force_fsm.sv
module bkpt_force_fsm
    import dbg_bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_ok,
    input  logic hit,
    input  logic boundary,
    output logic fire
);

    force_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (arm_ok && hit) state_nx = FS_PEND;
            FS_PEND: begin
                if (!arm_ok)       state_nx = FS_IDLE;
                else if (boundary) state_nx = hit ? FS_PEND : FS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        fire = 1'b0;
        unique case (state)
            FS_IDLE: fire = 1'b0;
            FS_PEND: fire = arm_ok && boundary;
        endcase
    end

    AST_PEND_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_PEND && $past(state) == FS_IDLE) |-> $past(arm_ok && hit)); // R5

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |=> (state == FS_IDLE)); // R7

    AST_DISARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_ok |=> (state == FS_IDLE)); // R11

endmodule

// File: rtl/bkpt_tag_queue.sv
module bkpt_tag_queue #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch,
    input  logic tag_in,
    input  logic exec,
    input  logic flush,
    output logic head_tag
);

    logic [DEPTH-1:0] tags_q, tags_nx;
    logic [CW-1:0]    cnt_q, cnt_nx, base;
    logic             do_pop, do_push;

    always_comb begin
        do_pop  = exec && (cnt_q != '0) && !flush;
        base    = flush ? '0 : (do_pop ? cnt_q - 1'b1 : cnt_q);
        do_push = fetch && (base < CW'(DEPTH));
        if (flush)       tags_nx = '0;
        else if (do_pop) tags_nx = tags_q >> 1;
        else             tags_nx = tags_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (do_push && base == CW'(i)) tags_nx[i] = tag_in;
        end
        cnt_nx = do_push ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_q <= '0;
            cnt_q  <= '0;
        end else begin
            tags_q <= tags_nx;
            cnt_q  <= cnt_nx;
        end
    end

    assign head_tag = exec && (cnt_q != '0) && tags_q[0];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !fetch) |=> (cnt_q == '0 && tags_q == '0)); // R9

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int QDEPTH = 4,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [HALF_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_access,
    input  logic              bus_fetch,
    input  logic              insn_boundary,
    input  logic              q_head_exec,
    input  logic              q_flush,
    output logic              halt_req
);

    bkpt_ctrl_t        ctrl;
    logic [ADDR_W-1:0] match_addr;
    logic              addr_hit, force_fire, head_tag;
    logic              force_arm, tag_arm;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl       (ctrl),
        .match_addr (match_addr)
    );

    assign addr_hit  = (bus_addr == match_addr);
    assign force_arm = ctrl.enable && ctrl.forced;
    assign tag_arm   = ctrl.enable && !ctrl.forced;

    bkpt_force_fsm u_force (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_ok   (force_arm),
        .hit      (bus_access && addr_hit),
        .boundary (insn_boundary),
        .fire     (force_fire)
    );

    bkpt_tag_queue #(.DEPTH(QDEPTH)) u_tagq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch    (bus_fetch),
        .tag_in   (tag_arm && addr_hit),
        .exec     (q_head_exec),
        .flush    (q_flush),
        .head_tag (head_tag)
    );

    assign halt_req = force_fire || (tag_arm && head_tag);

    AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ctrl.enable); // R2

    AST_FORCED_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && ctrl.forced) |-> insn_boundary); // R5

endmodule

// File: tb/dbg_bkpt_unit_bench.sv
module dbg_bkpt_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [15:0] bus_addr;
    logic        bus_access, bus_fetch, insn_boundary, q_head_exec, q_flush;
    logic        halt_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_bkpt_unit u_dbg_bkpt_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_access(bus_access),
        .bus_fetch(bus_fetch), .insn_boundary(insn_boundary),
        .q_head_exec(q_head_exec), .q_flush(q_flush), .halt_req(halt_req)
    );

    // forced-mode vectors, match = 0x1234: {addr, access, boundary, expected halt}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {16'h1234, 1'b1, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b1, 1'b1},
        {16'h0000, 1'b0, 1'b1, 1'b0},
        {16'h1235, 1'b1, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b1, 1'b0},
        {16'h1234, 1'b1, 1'b1, 1'b0},
        {16'h0000, 1'b0, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b1, 1'b1},
        {16'h1234, 1'b1, 1'b0, 1'b0},
        {16'h1234, 1'b1, 1'b1, 1'b1},
        {16'h0000, 1'b0, 1'b1, 1'b1},
        {16'h0000, 1'b0, 1'b1, 1'b0},
        {16'h3412, 1'b1, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (halt_req !== exp) begin
            n_fail++;
            $display("FAIL %s: halt_req actual %b expected %b at %0t", req, halt_req, exp, $time);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic acc, input logic fet,
                        input logic bnd, input logic ex, input logic fl,
                        input logic exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_access = acc; bus_fetch = fet;
        insn_boundary = bnd; q_head_exec = ex; q_flush = fl;
        #1 check(exp, req);
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_access = 0; bus_fetch = 0; insn_boundary = 0; q_head_exec = 0; q_flush = 0;
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; bus_addr = 0;
        bus_access = 0; bus_fetch = 0; insn_boundary = 0; q_head_exec = 0; q_flush = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state, access to 0x0000 never halts
        step(16'h0000, 1, 0, 0, 0, 0, 0, "R1");
        step(16'h0000, 1, 0, 1, 0, 0, 0, "R1");
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R1");

        // R2/R3: forced select but enable clear (0x02)
        cfg(2'd1, 8'h12); cfg(2'd2, 8'h34); cfg(2'd0, 8'h02);
        step(16'h1234, 1, 0, 0, 0, 0, 0, "R2");
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R2");

        // R3/R5/R6/R7: forced and enabled (0x03, upper bits set to show they are ignored)
        cfg(2'd0, 8'hF3);
        for (int i = 0; i < NV; i++)
            step(VEC[i][18:3], VEC[i][2], 1'b0, VEC[i][1], 1'b0, 1'b0, VEC[i][0], "R5/R6/R7 vector");

        // R4: select 3 changes nothing
        cfg(2'd3, 8'h00);
        step(16'h1234, 1, 0, 0, 0, 0, 0, "R4");
        step(16'h0000, 0, 0, 1, 0, 0, 1, "R4");
        // R4: high half only -> 0x5634
        cfg(2'd1, 8'h56);
        step(16'h1234, 1, 0, 0, 0, 0, 0, "R4");
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R4");
        step(16'h5634, 1, 0, 0, 0, 0, 0, "R4");
        step(16'h0000, 0, 0, 1, 0, 0, 1, "R4");
        // R4: low half only -> 0x5678
        cfg(2'd2, 8'h78);
        step(16'h5678, 1, 0, 0, 0, 0, 0, "R4");
        step(16'h0000, 0, 0, 1, 0, 0, 1, "R4");

        // R11: pending hit dropped by mode switch
        step(16'h5678, 1, 0, 0, 0, 0, 0, "R11");
        cfg(2'd0, 8'h01);
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R11");
        // R11: pending hit dropped by disable, not revived
        cfg(2'd0, 8'h03);
        step(16'h5678, 1, 0, 0, 0, 0, 0, "R11");
        cfg(2'd0, 8'h02);
        cfg(2'd0, 8'h03);
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R11");

        // tagged mode, match 0x1234
        cfg(2'd1, 8'h12); cfg(2'd2, 8'h34); cfg(2'd0, 8'h01);
        // R10: plain access plus boundaries
        step(16'h1234, 1, 0, 0, 0, 0, 0, "R10");
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R10");
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R10");
        // R8: fetch three opcodes, middle one tagged
        step(16'h1230, 1, 1, 0, 0, 0, 0, "R8");
        step(16'h1234, 1, 1, 0, 0, 0, 0, "R8");
        step(16'h1236, 1, 1, 0, 0, 0, 0, "R8");
        step(16'h0000, 0, 0, 0, 1, 0, 0, "R8 untagged head");
        step(16'h0000, 0, 0, 0, 1, 0, 1, "R8 tagged head");
        step(16'h0000, 0, 0, 0, 1, 0, 0, "R8 trailing");
        step(16'h0000, 0, 0, 0, 1, 0, 0, "R8 empty");
        // R8: fetch and execute in the same cycle
        step(16'h1234, 1, 1, 0, 0, 0, 0, "R8");
        step(16'h2000, 1, 1, 0, 1, 0, 1, "R8 overlap");
        step(16'h0000, 0, 0, 0, 1, 0, 0, "R8 overlap");
        // R9: flush discards tags
        step(16'h1234, 1, 1, 0, 0, 0, 0, "R9");
        step(16'h0000, 0, 0, 0, 0, 1, 0, "R9");
        step(16'h2000, 1, 1, 0, 0, 0, 0, "R9");
        step(16'h0000, 0, 0, 0, 1, 0, 0, "R9");
        // R9: fetch during flush enters empty queue
        step(16'h1230, 1, 1, 0, 0, 0, 0, "R9");
        step(16'h1234, 1, 1, 0, 0, 1, 0, "R9");
        step(16'h0000, 0, 0, 0, 1, 0, 1, "R9 refetch");
        // R2: tagged with enable clear
        cfg(2'd0, 8'h00);
        step(16'h1234, 1, 1, 0, 0, 0, 0, "R2");
        step(16'h0000, 0, 0, 1, 1, 0, 0, "R2");

        step(16'h0000, 0, 0, 0, 0, 0, 0, "idle");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule